// File: doc/BRIEF.md
# Multi-Format Signed Integer Adder

This block adds two signed words held in one of three number encodings: sign-magnitude, one's complement or two's complement. A two-bit format select picks the encoding for each operation. The sum comes back in the same encoding, together with an overflow flag, a carry flag and a flag that marks a negative-zero result. A single combinational datapath covers all three formats. It includes the magnitude compare-and-subtract needed for sign-magnitude operands of opposite sign and the end-around carry that one's complement requires.

The result is registered. A strobe qualifies each operation. Results and a result-valid flag appear one clock after the strobe, and the outputs keep their last value while the strobe is low. The word width is a parameter with a default of 8.

Top module: `signed_fmt_adder`

## Requirements
- R1: With fmt = 2'b00 or 2'b11 (two's complement), sum is the low W bits of op_a + op_b taken as unsigned, and carry is bit W of that addition.
- R2: In two's complement, ovf is 1 exactly when op_a and op_b have equal MSBs and the MSB of sum differs from them. negzero is always 0.
- R3: With fmt = 2'b01 (one's complement), the unsigned sum is formed first. If it carries out of the MSB, 1 is added back into the LSB. carry reports that first carry-out.
- R4: In one's complement, ovf is 1 exactly when the operand MSBs are equal and the MSB of the final sum, taken after the end-around carry, differs from them.
- R5: In one's complement, negzero is 1 exactly when the sum is all ones.
- R6: With fmt = 2'b10 (sign-magnitude, MSB is the sign with 1 meaning negative, and the low W-1 bits are the magnitude), operands of equal sign have their magnitudes added. The shared sign is kept and the magnitude wraps modulo 2^(W-1). Both carry and ovf equal the carry out of the magnitude field.
- R7: In sign-magnitude, operands of opposite sign and unequal magnitude give the larger magnitude minus the smaller, with the sign of the larger. ovf and carry are 0.
- R8: In sign-magnitude, operands of opposite sign and equal magnitude give positive zero (all bits 0).
- R9: In sign-magnitude, negzero is 1 exactly when sum is 1 followed by W-1 zeros.
- R10: A strobe on in_valid at a clock edge loads sum, ovf, carry and negzero at that edge and raises out_valid for the next cycle. When in_valid is low, out_valid goes low and the other outputs keep their values.
- R11: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| fmt | input | 2 | Encoding: 00/11 two's, 01 one's, 10 sign-magnitude |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| sum | output | W | Sum in the selected encoding |
| ovf | output | 1 | Signed overflow |
| carry | output | 1 | Carry out (magnitude carry in sign-magnitude) |
| negzero | output | 1 | Result is the negative-zero code |

## Verification
Two flags can rise together in sign-magnitude mode: overflow and negative zero. When two negative operands have magnitudes that sum to exactly 2^(W-1), the magnitude wraps to zero under a negative sign. The bench applies -64 + -64 in sign-magnitude and expects sum 8'h80 with ovf, carry and negzero all set in the same result. In one's complement, the end-around carry and overflow can also fall in the same cycle. The bench checks this with 8'h80 + 8'h80, which must give 8'h01 with both carry and ovf set.

// File: rtl/signed_fmt_adder.sv
module signed_fmt_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   fmt,
  output logic         out_valid,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         carry,
  output logic         negzero
);
  localparam int M = W - 1;
  localparam logic [1:0] FMT_ONES = 2'b01;
  localparam logic [1:0] FMT_SMAG = 2'b10;

  logic [W:0]   raw;
  logic [W-1:0] ones_s;
  logic         sa, sb, a_ge;
  logic [M-1:0] ma, mb, mdiff;
  logic [M:0]   madd;
  logic [W-1:0] n_sum;
  logic         n_ovf, n_carry, n_nz;

  assign raw    = {1'b0, op_a} + {1'b0, op_b};
  assign ones_s = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  assign sa     = op_a[W-1];
  assign sb     = op_b[W-1];
  assign ma     = op_a[M-1:0];
  assign mb     = op_b[M-1:0];
  assign madd   = {1'b0, ma} + {1'b0, mb};
  assign a_ge   = (ma >= mb);
  assign mdiff  = a_ge ? (ma - mb) : (mb - ma);

  always_comb begin
    case (fmt)
      FMT_ONES: begin
        n_sum   = ones_s;
        n_carry = raw[W];
        n_ovf   = (sa == sb) && (ones_s[W-1] != sa);
        n_nz    = &ones_s;
      end
      FMT_SMAG: begin
        if (sa == sb) begin
          n_sum   = {sa, madd[M-1:0]};
          n_carry = madd[M];
          n_ovf   = madd[M];
        end else begin
          n_sum   = {(mdiff == '0) ? 1'b0 : (a_ge ? sa : sb), mdiff};
          n_carry = 1'b0;
          n_ovf   = 1'b0;
        end
        n_nz = (n_sum == {1'b1, {M{1'b0}}});
      end
      default: begin
        n_sum   = raw[W-1:0];
        n_carry = raw[W];
        n_ovf   = (sa == sb) && (raw[W-1] != sa);
        n_nz    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      ovf       <= 1'b0;
      carry     <= 1'b0;
      negzero   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum     <= n_sum;
        ovf     <= n_ovf;
        carry   <= n_carry;
        negzero <= n_nz;
      end
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum) && $stable(ovf) && $stable(carry) && $stable(negzero)));
  assert_twos_no_negzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (fmt == 2'b00 || fmt == 2'b11)) |=> !negzero);
  assert_twos_mixed_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (fmt == 2'b00 || fmt == 2'b11) && (sa != sb)) |=> !ovf);
  assert_smag_mixed_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == FMT_SMAG && (sa != sb)) |=> (!ovf && !carry));
  assert_smag_equal_mag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == FMT_SMAG && (sa != sb) && (ma == mb)) |=> (sum == '0));
endmodule

// File: tb/signed_fmt_adder_tb.sv
`timescale 1ns/1ps
module signed_fmt_adder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [1:0] fmt = '0;
  logic       out_valid, ovf, carry, negzero;
  logic [7:0] sum;
  int vectors = 0;
  int errors = 0;

  always #2 clk = ~clk;

  signed_fmt_adder #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .fmt(fmt), .out_valid(out_valid), .sum(sum), .ovf(ovf), .carry(carry),
    .negzero(negzero));

  // expected {sum, ovf, carry, negzero}
  function automatic logic [10:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic [1:0] f);
    logic [8:0] t;
    logic [7:0] s;
    int x, y, r;
    logic o, c, z;
    t = {1'b0, a} + {1'b0, b};
    if (f == 2'b01) begin
      s = t[8] ? t[7:0] + 8'd1 : t[7:0];
      c = t[8];
      o = (a[7] == b[7]) && (s[7] != a[7]);
      z = (s == 8'hFF);
    end else if (f == 2'b10) begin
      x = int'(a[6:0]);
      y = int'(b[6:0]);
      if (a[7] == b[7]) begin
        r = x + y;
        c = (r > 127);
        o = c;
        s = {a[7], 7'(r % 128)};
      end else begin
        c = 1'b0;
        o = 1'b0;
        if (x == y) s = 8'h00;
        else if (x > y) s = {a[7], 7'(x - y)};
        else s = {b[7], 7'(y - x)};
      end
      z = (s == 8'h80);
    end else begin
      s = t[7:0];
      c = t[8];
      o = (a[7] == b[7]) && (s[7] != a[7]);
      z = 1'b0;
    end
    return {s, o, c, z};
  endfunction

  task automatic check(input string tag, input logic [10:0] exp, input logic ev);
    vectors++;
    if ({sum, ovf, carry, negzero} !== exp || out_valid !== ev) begin
      errors++;
      $display("FAIL %s: got sum=%h ovf=%b carry=%b nz=%b vld=%b, expected sum=%h ovf=%b carry=%b nz=%b vld=%b",
               tag, sum, ovf, carry, negzero, out_valid,
               exp[10:3], exp[2], exp[1], exp[0], ev);
    end
  endtask

  task automatic apply(input string tag, input logic [7:0] a, input logic [7:0] b,
                       input logic [1:0] f);
    op_a = a; op_b = b; fmt = f; in_valid = 1'b1;
    @(negedge clk);
    check(tag, model(a, b, f), 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [10:0] held;
    string tg;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R11 reset", 11'd0, 1'b0);
    rst_n = 1'b1;

    apply("R1 twos carry", 8'hFF, 8'hFF, 2'b00);
    apply("R1 twos alt code", 8'h12, 8'h34, 2'b11);
    apply("R2 twos ovf", 8'h7F, 8'h01, 2'b00);
    apply("R2 twos no negzero", 8'h80, 8'h00, 2'b00);
    apply("R3 ones end-around", 8'hFE, 8'hFE, 2'b01);
    apply("R4 ones ovf with carry", 8'h80, 8'h80, 2'b01);
    apply("R5 ones negzero", 8'h0F, 8'hF0, 2'b01);
    apply("R6 smag pos", 8'h05, 8'h03, 2'b10);
    apply("R6 smag neg", 8'h85, 8'h83, 2'b10);
    apply("R6 smag wrap", 8'h40, 8'h40, 2'b10);
    apply("R9 smag ovf negzero", 8'hC0, 8'hC0, 2'b10);
    apply("R7 smag a larger", 8'h07, 8'h85, 2'b10);
    apply("R7 smag b larger", 8'h03, 8'h87, 2'b10);
    apply("R8 smag cancel", 8'h07, 8'h87, 2'b10);
    apply("R8 smag cancel neg first", 8'h87, 8'h07, 2'b10);
    apply("R9 smag neg zeros", 8'h80, 8'h80, 2'b10);

    held = model(8'h80, 8'h80, 2'b10);
    op_a = 8'h11; op_b = 8'h22; fmt = 2'b00; in_valid = 1'b0;
    @(negedge clk);
    check("R10 hold", held, 1'b0);

    for (int i = 0; i < 1200; i++) begin
      logic [1:0] f;
      f = 2'($urandom);
      tg = (f == 2'b01) ? "R3 R4 R5 random ones" :
           (f == 2'b10) ? "R6 R7 R9 random smag" : "R1 R2 random twos";
      if ($urandom_range(0, 9) == 0) begin
        held = {sum, ovf, carry, negzero};
        op_a = 8'($urandom); op_b = 8'($urandom); fmt = f; in_valid = 1'b0;
        @(negedge clk);
        check("R10 random bubble", held, 1'b0);
      end else begin
        apply(tg, 8'($urandom), 8'($urandom), f);
      end
    end

    in_valid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule